// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits beside a small 8-bit CPU core and decides when the core must break off normal execution to run a handler. It serves five request sources: two external request lines, two timer overflow events and one serial event. Each source has its own enable bit and its own priority bit, and a global enable masks them all. The two external lines are active low. Each can be set to latch a falling edge or to follow the low level of the line.

Request flags are captured at a machine-cycle strobe that the core gives late in each machine cycle. The captured snapshot is judged at the following strobe. A dispatch happens only on the last cycle of an instruction, only when that instruction does not block it, and only when no handler of the same or a higher level is running. A dispatch gives a one-cycle vector request that carries the source index and the handler address. The block keeps one in-service bit per level. A return pulse from the core clears the highest in-service bit.

Top module: `irq_arbiter`

## Requirements
- R1: After a synchronous reset, `vec_req` is 0 and `in_svc` is 2'b00.
- R2: Source indices are 0 = external line 0, 1 = timer 0, 2 = external line 1, 3 = timer 1, 4 = serial. Within one level the lowest index wins. On a dispatch, `vec_src` carries the index and `vec_addr` is 0x0003 + 8 × index.
- R3: A source whose `src_en` bit is 0 is never dispatched. When `glob_en` is 0, no source is dispatched. A flag that is still pending is dispatched once it is enabled again.
- R4: When a high-level request (`src_hi` bit 1) and a low-level request are pending together, the high-level one is dispatched first, whatever their indices.
- R5: A high-level request can preempt a running low-level handler. A low-level request never starts while any handler is in service. A high-level request never starts while a high-level handler is in service.
- R6: In edge mode (`ext_edge` bit 1), a line that was high at one strobe and low at the next raises a sticky flag. A line held low does not raise it again. In level mode the flag equals the inverted line value taken at the last strobe.
- R7: A request captured at one strobe is dispatched no earlier than the next strobe.
- R8: No dispatch happens at a strobe where `last_cyc` is 0 or `blk_instr` is 1. `vec_req` only rises right after a strobe where `last_cyc` is 1 and `blk_instr` is 0.
- R9: A dispatch sets the in-service bit of its level (bit 1 = high, bit 0 = low). A `reti` pulse clears the highest set bit.
- R10: A dispatch clears the flag of a timer source and of an edge-mode external source. Serial and level-mode flags stay as they are. A timer overflow in the same clock as its own dispatch leaves the flag set.
- R11: `vec_req` is high for exactly one clock per dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | 5 | Per-source enable, indexed by source |
| glob_en | input | 1 | Global enable |
| src_hi | input | 5 | Per-source level, 1 = high |
| ext_n | input | 2 | External request lines, active low |
| ext_edge | input | 2 | External capture mode, 1 = falling edge, 0 = level |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_req | input | 1 | Serial event level |
| mc_strobe | input | 1 | Machine-cycle sampling strobe |
| last_cyc | input | 1 | Current cycle is the final one of the instruction |
| blk_instr | input | 1 | Current instruction is a return or an enable/priority write |
| reti | input | 1 | Return-from-handler pulse |
| vec_req | output | 1 | One-cycle vector request |
| vec_src | output | 3 | Index of the dispatched source |
| vec_addr | output | 16 | Handler address |
| in_svc | output | 2 | In-service bits, [1] high level, [0] low level |

## Verification
Two events can land on the same clock edge: the auto-clear of a dispatched timer flag, and a fresh overflow on that same timer. The bench drives the timer overflow in the very clock whose strobe dispatches that timer. It then returns from the handler and gives one more strobe. A second dispatch of the same source must follow, which shows that the new event beat the clear. The same sequence without the coinciding pulse yields no second dispatch.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 5;
  localparam int SRC_W    = 3;
  localparam int NEXT     = 2;
  localparam int IDX_SER  = 4;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_ext_capture.sv
module irq_ext_capture (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic line_n,
  input  logic edge_mode,
  input  logic clr,
  output logic flag_d
);
  logic prev_q;
  logic flag_q;

  always_comb begin
    if (edge_mode)
      flag_d = (flag_q & ~clr) | (strobe & prev_q & ~line_n);
    else
      flag_d = strobe ? ~line_n : flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (strobe) prev_q <= line_n;
    end
  end
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_d
);
  logic flag_q;

  // a new event wins over a clear in the same clock
  assign flag_d = (flag_q & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int W  = 5,
  parameter int IW = 3
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       grant,
  input  logic       grant_hi,
  input  logic       reti,
  output logic [1:0] in_svc
);
  logic [1:0] base;
  logic [1:0] add;

  always_comb begin
    base = in_svc;
    if (reti) base = in_svc[1] ? {1'b0, in_svc[0]} : 2'b00;
    add = 2'b00;
    if (grant) add = grant_hi ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk) begin
    if (rst) in_svc <= 2'b00;
    else     in_svc <= base | add;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     VEC_BASE = 16'h0003,
  parameter logic [15:0]     VEC_STEP = 16'h0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_en,
  input  logic              glob_en,
  input  logic [NSRC-1:0]   src_hi,
  input  logic [NEXT-1:0]   ext_n,
  input  logic [NEXT-1:0]   ext_edge,
  input  logic [NEXT-1:0]   tmr_ovf,
  input  logic              ser_req,
  input  logic              mc_strobe,
  input  logic              last_cyc,
  input  logic              blk_instr,
  input  logic              reti,
  output logic              vec_req,
  output logic [SRC_W-1:0]  vec_src,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [1:0]        in_svc
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(VEC_STEP);

  src_vec_t          flag_d;
  src_vec_t          snap_q;
  src_vec_t          clr;
  src_vec_t          auto_clr;
  src_vec_t          armed;
  logic              hi_any, lo_any, take_hi, take_lo, go;
  logic [SRC_W-1:0]  hi_idx, lo_idx, sel;

  // even indices are external lines, odd indices below the serial slot are timers
  for (genvar g = 0; g < NEXT; g++) begin : g_pair
    irq_ext_capture u_ext (
      .clk(clk), .rst(rst), .strobe(mc_strobe), .line_n(ext_n[g]),
      .edge_mode(ext_edge[g]), .clr(clr[2*g]), .flag_d(flag_d[2*g])
    );
    irq_sticky u_tmr (
      .clk(clk), .rst(rst), .set(tmr_ovf[g]), .clr(clr[2*g+1]),
      .flag_d(flag_d[2*g+1])
    );
    assign auto_clr[2*g]   = ext_edge[g];
    assign auto_clr[2*g+1] = 1'b1;
  end
  assign flag_d[IDX_SER]   = ser_req;
  assign auto_clr[IDX_SER] = 1'b0;

  assign armed = snap_q & src_en & {NSRC{glob_en}};

  irq_pick #(.W(NSRC), .IW(SRC_W)) u_pick_hi (
    .req(armed & src_hi), .any(hi_any), .idx(hi_idx)
  );
  irq_pick #(.W(NSRC), .IW(SRC_W)) u_pick_lo (
    .req(armed & ~src_hi), .any(lo_any), .idx(lo_idx)
  );

  assign take_hi = hi_any & ~in_svc[1];
  assign take_lo = lo_any & (in_svc == 2'b00) & ~take_hi;
  assign go      = mc_strobe & last_cyc & ~blk_instr & (take_hi | take_lo);
  assign sel     = take_hi ? hi_idx : lo_idx;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      clr[i] = go && (sel == SRC_W'(i)) && auto_clr[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q   <= '0;
      vec_req  <= 1'b0;
      vec_src  <= '0;
      vec_addr <= '0;
    end else begin
      if (mc_strobe) snap_q <= flag_d;
      vec_req <= go;
      if (go) begin
        vec_src  <= sel;
        vec_addr <= BASE_A + STEP_A * ADDR_W'(sel);
      end
    end
  end

  irq_level_track u_track (
    .clk(clk), .rst(rst), .grant(go), .grant_hi(take_hi), .reti(reti),
    .in_svc(in_svc)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic       mc_strobe,
  input logic       last_cyc,
  input logic       blk_instr,
  input logic       reti,
  input logic       vec_req,
  input logic [2:0] vec_src,
  input logic [1:0] in_svc
);
  // R8
  dispatch_gate_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> $past(mc_strobe && last_cyc && !blk_instr));
  // R2
  src_range_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> (vec_src < 3'd5));
  // R9
  svc_set_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> (in_svc != 2'b00));
  // R9
  svc_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_svc[0]) |-> vec_req);
  // R5
  no_hi_nest_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> !$past(in_svc[1]));
  // R5
  lo_no_nest_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_req && $past(in_svc == 2'b01) && !$past(reti)) |-> (in_svc == 2'b11));
endmodule

bind irq_arbiter irq_arbiter_chk u_irq_arbiter_chk (
  .clk(clk), .rst(rst), .mc_strobe(mc_strobe), .last_cyc(last_cyc),
  .blk_instr(blk_instr), .reti(reti), .vec_req(vec_req), .vec_src(vec_src),
  .in_svc(in_svc)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  src_en, src_hi;
  logic        glob_en, ser_req, mc_strobe, last_cyc, blk_instr, reti;
  logic [1:0]  ext_n, ext_edge, tmr_ovf;
  logic        vec_req;
  logic [2:0]  vec_src;
  logic [15:0] vec_addr;
  logic [1:0]  in_svc;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst(rst), .src_en(src_en), .glob_en(glob_en), .src_hi(src_hi),
    .ext_n(ext_n), .ext_edge(ext_edge), .tmr_ovf(tmr_ovf), .ser_req(ser_req),
    .mc_strobe(mc_strobe), .last_cyc(last_cyc), .blk_instr(blk_instr),
    .reti(reti), .vec_req(vec_req), .vec_src(vec_src), .vec_addr(vec_addr),
    .in_svc(in_svc)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic check_req(string tag, logic exp_req, int exp_src);
    logic [15:0] ea;
    ea = 16'(3 + 8 * exp_src);
    n_chk++;
    if (exp_req) begin
      if (!(vec_req === 1'b1 && vec_src === 3'(exp_src) && vec_addr === ea)) begin
        n_bad++;
        $display("FAIL %s: req=%b src=%0d addr=%h, expected req=1 src=%0d addr=%h",
                 tag, vec_req, vec_src, vec_addr, exp_src, ea);
      end
    end else if (vec_req !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: req=%b src=%0d, expected req=0", tag, vec_req, vec_src);
    end
  endtask

  task automatic check_svc(string tag, logic [1:0] exp);
    n_chk++;
    if (in_svc !== exp) begin
      n_bad++;
      $display("FAIL %s: in_svc=%b, expected %b", tag, in_svc, exp);
    end
  endtask

  task automatic strobe(logic last, logic blk, logic [1:0] ovf = 2'b00);
    @(negedge clk);
    mc_strobe = 1'b1; last_cyc = last; blk_instr = blk; tmr_ovf = ovf;
    @(negedge clk);
    mc_strobe = 1'b0; last_cyc = 1'b0; blk_instr = 1'b0; tmr_ovf = 2'b00;
  endtask

  task automatic idle_after();
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_tmr(logic [1:0] ovf);
    @(negedge clk); tmr_ovf = ovf;
    @(negedge clk); tmr_ovf = 2'b00;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic quiesce();
    strobe(1'b0, 1'b0); strobe(1'b0, 1'b0);
    do_reti(); do_reti();
  endtask

  task automatic t_reset();
    check_req("R1 reset req", 1'b0, 0);
    check_svc("R1 reset svc", 2'b00);
  endtask

  task automatic t_edge();
    ext_n[0] = 1'b0;
    strobe(1'b1, 1'b0); check_req("R7 edge captured only", 1'b0, 0);
    strobe(1'b1, 1'b0); check_req("R2 R6 edge dispatch ext0", 1'b1, 0);
    check_svc("R9 low level set", 2'b01);
    strobe(1'b1, 1'b0); check_req("R11 single pulse", 1'b0, 0);
    do_reti(); check_svc("R9 reti clears low", 2'b00);
    strobe(1'b1, 1'b0); check_req("R6 R10 held low no retrigger", 1'b0, 0);
    ext_n[0] = 1'b1; strobe(1'b1, 1'b0);
    ext_n[0] = 1'b0; strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0); check_req("R6 second falling edge", 1'b1, 0);
    ext_n[0] = 1'b1; quiesce();
  endtask

  task automatic t_level();
    ext_n[1] = 1'b0;
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0); check_req("R2 R6 level dispatch ext1", 1'b1, 2);
    do_reti();
    strobe(1'b1, 1'b0); check_req("R10 level flag kept", 1'b1, 2);
    ext_n[1] = 1'b1; quiesce();
    strobe(1'b1, 1'b0); check_req("R6 level follows line", 1'b0, 0);
  endtask

  task automatic t_order();
    ser_req = 1'b1; pulse_tmr(2'b11);
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0); check_req("R2 order tmr0 first", 1'b1, 1);
    strobe(1'b1, 1'b0); check_req("R5 low no nest", 1'b0, 0);
    do_reti();
    strobe(1'b1, 1'b0); check_req("R2 R10 tmr1 next", 1'b1, 3);
    do_reti();
    strobe(1'b1, 1'b0); check_req("R2 serial last", 1'b1, 4);
    do_reti();
    strobe(1'b1, 1'b0); check_req("R10 serial not cleared", 1'b1, 4);
    ser_req = 1'b0; quiesce();
  endtask

  task automatic t_prio();
    src_hi = 5'b01000; pulse_tmr(2'b11);
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0); check_req("R4 high beats low", 1'b1, 3);
    check_svc("R9 high level set", 2'b10);
    strobe(1'b1, 1'b0); check_req("R5 low waits for high", 1'b0, 0);
    do_reti();
    strobe(1'b1, 1'b0); check_req("R4 low after high", 1'b1, 1);
    pulse_tmr(2'b10);
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0); check_req("R5 high preempts low", 1'b1, 3);
    check_svc("R5 both levels", 2'b11);
    do_reti(); check_svc("R9 reti clears highest", 2'b01);
    do_reti(); check_svc("R9 reti clears low", 2'b00);
    src_hi = 5'b00000;
  endtask

  task automatic t_mask();
    src_en = 5'b11101; pulse_tmr(2'b01);
    strobe(1'b1, 1'b0); strobe(1'b1, 1'b0);
    check_req("R3 source disabled", 1'b0, 0);
    src_en = 5'b11111;
    strobe(1'b1, 1'b0); check_req("R3 pending after enable", 1'b1, 1);
    do_reti();
    glob_en = 1'b0; pulse_tmr(2'b10);
    strobe(1'b1, 1'b0); strobe(1'b1, 1'b0);
    check_req("R3 global mask", 1'b0, 0);
    glob_en = 1'b1;
    strobe(1'b1, 1'b0); check_req("R3 global restore", 1'b1, 3);
    do_reti();
  endtask

  task automatic t_block();
    pulse_tmr(2'b01);
    strobe(1'b1, 1'b0);
    strobe(1'b0, 1'b0); check_req("R8 not last cycle", 1'b0, 0);
    strobe(1'b1, 1'b1); check_req("R8 blocking instr", 1'b0, 0);
    strobe(1'b1, 1'b0); check_req("R8 released", 1'b1, 1);
    do_reti();
  endtask

  task automatic t_same_cycle();
    pulse_tmr(2'b01);
    strobe(1'b1, 1'b0);
    strobe(1'b1, 1'b0, 2'b01); check_req("R10 dispatch with new ovf", 1'b1, 1);
    do_reti();
    strobe(1'b1, 1'b0); check_req("R10 set wins over clear", 1'b1, 1);
    do_reti();
    strobe(1'b1, 1'b0); check_req("R10 cleared afterwards", 1'b0, 0);
    quiesce();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; src_en = 5'b11111; glob_en = 1'b1; src_hi = 5'b00000;
    ext_n = 2'b11; ext_edge = 2'b01; tmr_ovf = 2'b00; ser_req = 1'b0;
    mc_strobe = 1'b0; last_cyc = 1'b0; blk_instr = 1'b0; reti = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_edge();
    t_level();
    t_order();
    t_prio();
    t_mask();
    t_block();
    t_same_cycle();
    idle_after();
    summary();
    $finish;
  end
endmodule